// File: doc/BRIEF.md
# Vector Unit-Stride Memory Instruction Decoder

This block is a purely combinational decoder that sits in the issue path of a vector unit. It receives one 32-bit instruction word together with the live vector configuration: encoded element width, encoded register-group exponent, a configuration-invalid flag and an extension-enable bit. From these it decides whether the word is a contiguous (unit-stride) vector load or store. It then names the exact flavour, pulls out the register fields and judges whether the instruction may run under the present configuration.

Three outcomes are kept apart. A word that is not a unit-stride vector memory form raises `not_mine` so that other decoders can claim it. A recognised word that breaks a configuration rule raises `illegal`. A recognised and legal word leaves both low. In every recognised case a packed descriptor is built for the downstream memory sequencer. It carries the mask-bit spacing, the mask enable, the group exponent and the number of segment fields.

Top module: `vec_mem_decode`

## Requirements
- R1: A word is recognised only when bits [6:0] are 0000111 (load) or 0100111 (store), bits [24:20] are zero, and bits [28:26] with bits [14:12] form one of the flavours in R2 or R3. Any other word drives `not_mine`=1, `illegal`=0, `op`=0 and `desc`=0. A recognised word drives `not_mine`=0.
- R2: Load flavour on `op`, for width code bits [14:12] of 000 (byte), 101 (half), 110 (word) and 111 (element):
  - With bits [28:26]=100, the sign-extending loads give byte=1, half=2 and word=3. Width 111 is not recognised.
  - With bits [28:26]=000, the element load gives 4, and the zero-extending loads give byte=5, half=6 and word=7.
- R3: Store flavour on `op`, only with bits [28:26]=000: byte=8, half=9, word=10, element=11.
- R4: `vd` reflects bits [11:7] and `rs1` reflects bits [19:15] for every word.
- R5: A recognised word is illegal when its fixed memory width is wider than the element width. That is a half with `sew`=0, or a word with `sew`=0 or 1. The element width code 111 never fails this rule.
- R6: A recognised word is illegal whenever `cfg_invalid`=1 or `vec_enable`=0.
- R7: A recognised word is illegal when `vd` is not a multiple of 2^`lmul`.
- R8: A recognised word is illegal when `lmul`·(nf+1) > 8, where nf is bits [31:29] and `lmul` is taken as its encoded integer.
- R9: A recognised load with bit 25 = 0 (masked), `lmul` ≥ 2 and `vd` = 0 is illegal. Stores are exempt from this rule.
- R10: For a recognised word, `desc` has four fields:
  - [7:0] holds mlen = 1 << (`sew` + 3 − `lmul`).
  - [8] holds bit 25.
  - [10:9] holds `lmul`.
  - [14:11] holds nf+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction word under decode |
| sew | input | 2 | Encoded element width (0 = 8 bits … 3 = 64 bits) |
| lmul | input | 2 | Encoded register-group exponent |
| cfg_invalid | input | 1 | Vector configuration is invalid |
| vec_enable | input | 1 | Vector extension enabled |
| not_mine | output | 1 | Word is not a unit-stride vector memory form |
| illegal | output | 1 | Recognised form violates a configuration rule |
| op | output | 4 | Flavour code (0 = none) |
| vd | output | 5 | Data register field |
| rs1 | output | 5 | Base address register field |
| desc | output | 15 | Packed descriptor for the memory sequencer |

## Verification
The checker continuously enforces several relations between ports:
- An unrecognised word raises no `illegal`, carries no flavour and has a zero descriptor.
- A flavour code 8 and above always sits on the store opcode.
- A legal result never breaks register alignment, the segment limit or the masked-load overlap rule.
- A recognised descriptor always carries a single-bit mask spacing.

Only the bench scenarios can show the rest. This covers the exact flavour chosen for each width/mop pairing, the SEW-versus-width rejections and the store exemption from the overlap rule. It also covers the lmul=3 segment arithmetic and the exact descriptor values, all checked against an independent model.

// File: rtl/vmd_pkg.sv
package vmd_pkg;

    localparam int INSTR_W = 32;
    localparam int REG_W   = 5;
    localparam int NF_W    = 3;
    localparam int CFG_W   = 2;
    localparam int MLEN_W  = 8;
    localparam int CNT_W   = 4;
    localparam int OP_W    = 4;
    localparam int DESC_W  = MLEN_W + 1 + CFG_W + CNT_W;
    localparam int LMUL_N  = 1 << CFG_W;
    localparam int SEG_LIMIT = 8;

    localparam logic [6:0] OPC_VLOAD  = 7'b0000111;
    localparam logic [6:0] OPC_VSTORE = 7'b0100111;

    localparam logic [2:0] MOP_UNIT    = 3'b000;
    localparam logic [2:0] MOP_SIGNED  = 3'b100;

    localparam logic [2:0] WD_BYTE = 3'b000;
    localparam logic [2:0] WD_HALF = 3'b101;
    localparam logic [2:0] WD_WORD = 3'b110;
    localparam logic [2:0] WD_ELEM = 3'b111;

    typedef enum logic [OP_W-1:0] {
        VOP_NONE  = 4'd0,
        VOP_LD_BS = 4'd1,
        VOP_LD_HS = 4'd2,
        VOP_LD_WS = 4'd3,
        VOP_LD_E  = 4'd4,
        VOP_LD_BU = 4'd5,
        VOP_LD_HU = 4'd6,
        VOP_LD_WU = 4'd7,
        VOP_ST_B  = 4'd8,
        VOP_ST_H  = 4'd9,
        VOP_ST_W  = 4'd10,
        VOP_ST_E  = 4'd11
    } vmd_op_e;

    typedef struct packed {
        logic [NF_W-1:0]  nf;
        logic [2:0]       mop;
        logic             vm;
        logic [4:0]       lumop;
        logic [REG_W-1:0] rs1;
        logic [2:0]       width;
        logic [REG_W-1:0] vd;
        logic [6:0]       opcode;
    } vmd_fields_t;

    typedef struct packed {
        logic [CNT_W-1:0]  fields;
        logic [CFG_W-1:0]  lmul;
        logic              vm;
        logic [MLEN_W-1:0] mlen;
    } vmd_desc_t;

    // log2 of the fixed memory size in bytes; element width returns 0 (unused)
    function automatic logic [1:0] fixed_size_log2(input logic [2:0] wd);
        case (wd)
            WD_HALF: fixed_size_log2 = 2'd1;
            WD_WORD: fixed_size_log2 = 2'd2;
            default: fixed_size_log2 = 2'd0;
        endcase
    endfunction

    function automatic logic op_is_load(input vmd_op_e op);
        op_is_load = (op >= VOP_LD_BS) && (op <= VOP_LD_WU);
    endfunction

endpackage

// File: rtl/vmd_match.sv
module vmd_match
    import vmd_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output vmd_fields_t        fld,
    output vmd_op_e            op,
    output logic               hit
);
    logic is_ld_opc;
    logic is_st_opc;
    logic unit_ok;

    assign fld       = vmd_fields_t'(instr);
    assign is_ld_opc = (fld.opcode == OPC_VLOAD);
    assign is_st_opc = (fld.opcode == OPC_VSTORE);
    assign unit_ok   = (fld.lumop == 5'd0);

    always_comb begin
        op = VOP_NONE;
        if (unit_ok && is_ld_opc && fld.mop == MOP_SIGNED) begin
            case (fld.width)
                WD_BYTE: op = VOP_LD_BS;
                WD_HALF: op = VOP_LD_HS;
                WD_WORD: op = VOP_LD_WS;
                default: op = VOP_NONE;
            endcase
        end else if (unit_ok && is_ld_opc && fld.mop == MOP_UNIT) begin
            case (fld.width)
                WD_BYTE: op = VOP_LD_BU;
                WD_HALF: op = VOP_LD_HU;
                WD_WORD: op = VOP_LD_WU;
                WD_ELEM: op = VOP_LD_E;
                default: op = VOP_NONE;
            endcase
        end else if (unit_ok && is_st_opc && fld.mop == MOP_UNIT) begin
            case (fld.width)
                WD_BYTE: op = VOP_ST_B;
                WD_HALF: op = VOP_ST_H;
                WD_WORD: op = VOP_ST_W;
                WD_ELEM: op = VOP_ST_E;
                default: op = VOP_NONE;
            endcase
        end
    end

    assign hit = (op != VOP_NONE);

endmodule

// File: rtl/vmd_legal.sv
module vmd_legal
    import vmd_pkg::*;
(
    input  logic             hit,
    input  vmd_op_e          op,
    input  logic [2:0]       width,
    input  logic [REG_W-1:0] vd,
    input  logic             vm,
    input  logic [NF_W-1:0]  nf,
    input  logic [CFG_W-1:0] sew,
    input  logic [CFG_W-1:0] lmul,
    input  logic             cfg_invalid,
    input  logic             vec_enable,
    output logic             illegal
);
    localparam int PROD_W = CFG_W + CNT_W;

    logic [LMUL_N-1:0] align_ok;
    logic              bad_cfg;
    logic              bad_width;
    logic              bad_align;
    logic              bad_seg;
    logic              bad_overlap;
    logic [PROD_W-1:0] seg_prod;
    logic [CNT_W-1:0]  seg_cnt;

    // one alignment test per possible group exponent
    genvar g;
    generate
        for (g = 0; g < LMUL_N; g++) begin : g_align
            if (g == 0) begin : g_any
                assign align_ok[g] = 1'b1;
            end else begin : g_mask
                assign align_ok[g] = (vd[g-1:0] == '0);
            end
        end
    endgenerate

    assign bad_cfg   = cfg_invalid || !vec_enable;
    assign bad_width = (width != WD_ELEM) && (fixed_size_log2(width) > sew);
    assign bad_align = !align_ok[lmul];

    assign seg_cnt  = {1'b0, nf} + CNT_W'(1);
    assign seg_prod = PROD_W'(lmul) * PROD_W'(seg_cnt);
    assign bad_seg  = (seg_prod > PROD_W'(SEG_LIMIT));

    assign bad_overlap = op_is_load(op) && !vm && (lmul >= CFG_W'(2)) && (vd == '0);

    assign illegal = hit && (bad_cfg || bad_width || bad_align || bad_seg || bad_overlap);

endmodule

// File: rtl/vmd_desc.sv
module vmd_desc
    import vmd_pkg::*;
(
    input  logic              hit,
    input  logic [CFG_W-1:0]  sew,
    input  logic [CFG_W-1:0]  lmul,
    input  logic              vm,
    input  logic [NF_W-1:0]   nf,
    output logic [DESC_W-1:0] desc
);
    localparam int EXP_W = CFG_W + 2;

    logic [EXP_W-1:0] mexp;
    vmd_desc_t        d;

    assign mexp     = EXP_W'(sew) + EXP_W'(3) - EXP_W'(lmul);
    assign d.mlen   = MLEN_W'(1) << mexp;
    assign d.vm     = vm;
    assign d.lmul   = lmul;
    assign d.fields = {1'b0, nf} + CNT_W'(1);

    assign desc = hit ? DESC_W'(d) : '0;

endmodule

// File: rtl/vec_mem_decode.sv
module vec_mem_decode
    import vmd_pkg::*;
(
    input  logic [31:0] instr,
    input  logic [1:0]  sew,
    input  logic [1:0]  lmul,
    input  logic        cfg_invalid,
    input  logic        vec_enable,
    output logic        not_mine,
    output logic        illegal,
    output logic [3:0]  op,
    output logic [4:0]  vd,
    output logic [4:0]  rs1,
    output logic [14:0] desc
);
    vmd_fields_t fld;
    vmd_op_e     op_sel;
    logic        hit;

    vmd_match u_match (
        .instr (instr),
        .fld   (fld),
        .op    (op_sel),
        .hit   (hit)
    );

    vmd_legal u_legal (
        .hit         (hit),
        .op          (op_sel),
        .width       (fld.width),
        .vd          (fld.vd),
        .vm          (fld.vm),
        .nf          (fld.nf),
        .sew         (sew),
        .lmul        (lmul),
        .cfg_invalid (cfg_invalid),
        .vec_enable  (vec_enable),
        .illegal     (illegal)
    );

    vmd_desc u_desc (
        .hit  (hit),
        .sew  (sew),
        .lmul (lmul),
        .vm   (fld.vm),
        .nf   (fld.nf),
        .desc (desc)
    );

    assign not_mine = !hit;
    assign op       = op_sel;
    assign vd       = fld.vd;
    assign rs1      = fld.rs1;

endmodule

// File: rtl/vec_mem_decode_chk.sv
module vec_mem_decode_chk (
    input logic [31:0] instr,
    input logic [1:0]  sew,
    input logic [1:0]  lmul,
    input logic        cfg_invalid,
    input logic        vec_enable,
    input logic        not_mine,
    input logic        illegal,
    input logic [3:0]  op,
    input logic [4:0]  vd,
    input logic [4:0]  rs1,
    input logic [14:0] desc
);
    logic legal_hit;
    int   seg_prod;
    int   align_mask;

    assign legal_hit  = !not_mine && !illegal;
    assign seg_prod   = int'(lmul) * (int'(instr[31:29]) + 1);
    assign align_mask = (1 << lmul) - 1;

    always_comb begin
        AST_NOT_MINE_QUIET: assert (!not_mine || (!illegal && op == 4'd0 && desc == 15'd0))
            else $error("unrecognised word produced output"); // R1
        AST_OP_PRESENT: assert (not_mine || (op != 4'd0 && op <= 4'd11))
            else $error("recognised word without flavour"); // R2
        AST_STORE_OPCODE: assert (op < 4'd8 || instr[6:0] == 7'b0100111)
            else $error("store flavour on non-store opcode"); // R3
        AST_FIELDS: assert (vd == instr[11:7] && rs1 == instr[19:15])
            else $error("register fields mismatch"); // R4
        AST_CFG_BLOCK: assert (!(cfg_invalid || !vec_enable) || not_mine || illegal)
            else $error("legal under disabled configuration"); // R6
        AST_ALIGN: assert (!legal_hit || ((int'(vd) & align_mask) == 0))
            else $error("legal with misaligned register"); // R7
        AST_SEG_LIMIT: assert (!legal_hit || seg_prod <= 8)
            else $error("legal beyond segment limit"); // R8
        AST_MASK_OVERLAP: assert (!(legal_hit && op <= 4'd7 && !instr[25] && lmul >= 2'd2) || vd != 5'd0)
            else $error("masked load overlaps mask register"); // R9
        AST_MLEN_ONEHOT: assert (not_mine || $countones(desc[7:0]) == 1)
            else $error("mask spacing not a power of two"); // R10
    end

endmodule

bind vec_mem_decode vec_mem_decode_chk u_chk (
    .instr       (instr),
    .sew         (sew),
    .lmul        (lmul),
    .cfg_invalid (cfg_invalid),
    .vec_enable  (vec_enable),
    .not_mine    (not_mine),
    .illegal     (illegal),
    .op          (op),
    .vd          (vd),
    .rs1         (rs1),
    .desc        (desc)
);

// File: tb/vec_mem_decode_bench.sv
`timescale 1ns/1ps
module vec_mem_decode_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] instr = '0;
    logic [1:0]  sew = '0;
    logic [1:0]  lmul = '0;
    logic        cfg_invalid = 1'b0;
    logic        vec_enable = 1'b1;
    logic        not_mine;
    logic        illegal;
    logic [3:0]  op;
    logic [4:0]  vd;
    logic [4:0]  rs1;
    logic [14:0] desc;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    vec_mem_decode u_vec_mem_decode (
        .instr (instr), .sew (sew), .lmul (lmul),
        .cfg_invalid (cfg_invalid), .vec_enable (vec_enable),
        .not_mine (not_mine), .illegal (illegal), .op (op),
        .vd (vd), .rs1 (rs1), .desc (desc)
    );

    function automatic logic [31:0] mk(input int nf, input int mop, input bit vm,
                                       input int rb, input int wd, input int rd,
                                       input bit st);
        logic [31:0] w;
        w = '0;
        w[31:29] = 3'(nf);
        w[28:26] = 3'(mop);
        w[25]    = vm;
        w[19:15] = 5'(rb);
        w[14:12] = 3'(wd);
        w[11:7]  = 5'(rd);
        w[6:0]   = st ? 7'h27 : 7'h07;
        return w;
    endfunction

    task automatic model(input logic [31:0] w, input logic [1:0] s, input logic [1:0] l,
                         input logic inv, input logic en,
                         output logic e_nm, output logic e_ill, output logic [3:0] e_op,
                         output logic [14:0] e_desc, output string why);
        int msz;
        int nfv;
        bit ld;
        bit st;
        ld = (w[6:0] == 7'h07) && (w[24:20] == 0);
        st = (w[6:0] == 7'h27) && (w[24:20] == 0);
        e_op = 0;
        if (ld && w[28:26] == 3'b100) begin
            if (w[14:12] == 3'b000) e_op = 1;
            if (w[14:12] == 3'b101) e_op = 2;
            if (w[14:12] == 3'b110) e_op = 3;
        end else if (ld && w[28:26] == 3'b000) begin
            if (w[14:12] == 3'b000) e_op = 5;
            if (w[14:12] == 3'b101) e_op = 6;
            if (w[14:12] == 3'b110) e_op = 7;
            if (w[14:12] == 3'b111) e_op = 4;
        end else if (st && w[28:26] == 3'b000) begin
            if (w[14:12] == 3'b000) e_op = 8;
            if (w[14:12] == 3'b101) e_op = 9;
            if (w[14:12] == 3'b110) e_op = 10;
            if (w[14:12] == 3'b111) e_op = 11;
        end
        e_nm = (e_op == 0);
        e_ill = 0;
        why = "R1";
        e_desc = 0;
        if (!e_nm) begin
            nfv = int'(w[31:29]) + 1;
            msz = (w[14:12] == 3'b101) ? 2 : (w[14:12] == 3'b110) ? 4 : 1;
            if (inv || !en) begin e_ill = 1; why = "R6"; end
            else if (w[14:12] != 3'b111 && msz > (1 << s)) begin e_ill = 1; why = "R5"; end
            else if ((int'(w[11:7]) % (1 << l)) != 0) begin e_ill = 1; why = "R7"; end
            else if (int'(l) * nfv > 8) begin e_ill = 1; why = "R8"; end
            else if (e_op <= 7 && !w[25] && l >= 2 && w[11:7] == 0) begin e_ill = 1; why = "R9"; end
            else why = "R5/R7";
            e_desc = 15'((nfv << 11) | (int'(w[25]) << 8) | (int'(l) << 9) | (1 << (int'(s) + 3 - int'(l))));
        end
    endtask

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s got=0x%0h exp=0x%0h instr=0x%08h sew=%0d lmul=%0d", tag, got, exp, instr, sew, lmul);
        end
    endtask

    // drive one vector, sample mid-cycle, compare all outputs with the model
    task automatic apply(input logic [31:0] w, input logic [1:0] s, input logic [1:0] l,
                         input logic inv, input logic en, input string ill_tag);
        logic e_nm; logic e_ill; logic [3:0] e_op; logic [14:0] e_desc; string why;
        @(posedge clk);
        instr = w; sew = s; lmul = l; cfg_invalid = inv; vec_enable = en;
        #1;
        model(w, s, l, inv, en, e_nm, e_ill, e_op, e_desc, why);
        chk("R1 not_mine", int'(not_mine), int'(e_nm));
        chk((w[6:0] == 7'h27) ? "R3 op" : "R2 op", int'(op), int'(e_op));
        chk((ill_tag == "") ? why : ill_tag, int'(illegal), int'(e_ill));
        chk("R10 desc", int'(desc), int'(e_desc));
        chk("R4 fields", int'({vd, rs1}), int'({w[11:7], w[19:15]}));
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        rst = 1'b0;
        #1;
        chk("R1 reset not_mine", int'(not_mine), 1);
        chk("R1 reset desc", int'(desc), 0);

        // R2 / R10: plain element load, mlen=8, vm=1, fields=1
        apply(mk(0, 0, 1, 3, 7, 0, 0), 2'd0, 2'd0, 0, 1, "R2");
        chk("R10 elem desc", int'(desc), 15'h0908);
        apply(mk(0, 4, 1, 9, 0, 1, 0), 2'd0, 2'd0, 0, 1, "R2");
        apply(mk(0, 4, 1, 9, 7, 1, 0), 2'd3, 2'd0, 0, 1, "R2");    // signed + element: not mine
        apply(mk(0, 0, 1, 9, 6, 1, 0), 2'd2, 2'd0, 0, 1, "R2");
        // R5 width versus SEW
        apply(mk(0, 4, 1, 2, 5, 1, 0), 2'd0, 2'd0, 0, 1, "R5");
        apply(mk(0, 0, 1, 2, 6, 1, 1), 2'd1, 2'd0, 0, 1, "R5");
        apply(mk(0, 0, 1, 2, 6, 1, 1), 2'd2, 2'd0, 0, 1, "R5");
        apply(mk(0, 0, 1, 2, 7, 1, 1), 2'd0, 2'd0, 0, 1, "R3");
        // R6 configuration gates
        apply(mk(0, 0, 1, 2, 7, 1, 0), 2'd0, 2'd0, 1, 1, "R6");
        apply(mk(0, 0, 1, 2, 7, 1, 1), 2'd0, 2'd0, 0, 0, "R6");
        // R7 alignment
        apply(mk(0, 0, 1, 2, 7, 3, 0), 2'd2, 2'd2, 0, 1, "R7");
        apply(mk(0, 0, 1, 2, 7, 4, 0), 2'd2, 2'd2, 0, 1, "R7");
        // R8 segment limit
        apply(mk(3, 0, 1, 2, 7, 4, 0), 2'd2, 2'd2, 0, 1, "R8");
        apply(mk(4, 0, 1, 2, 7, 4, 0), 2'd2, 2'd2, 0, 1, "R8");
        apply(mk(1, 0, 1, 2, 7, 8, 1), 2'd3, 2'd3, 0, 1, "R8");
        apply(mk(2, 0, 1, 2, 7, 8, 1), 2'd3, 2'd3, 0, 1, "R8");
        // R9 mask overlap; stores exempt
        apply(mk(0, 0, 0, 2, 7, 0, 0), 2'd2, 2'd2, 0, 1, "R9");
        apply(mk(0, 0, 0, 2, 7, 0, 1), 2'd2, 2'd2, 0, 1, "R9");
        apply(mk(0, 0, 0, 2, 7, 0, 0), 2'd2, 2'd1, 0, 1, "R9");
        // R1 foreign words
        apply(mk(0, 0, 1, 2, 2, 1, 0), 2'd0, 2'd0, 0, 1, "R1");
        apply(mk(0, 0, 1, 2, 7, 1, 0) | 32'h0010_0000, 2'd0, 2'd0, 0, 1, "R1");
        apply(mk(0, 4, 1, 2, 0, 1, 1), 2'd0, 2'd0, 0, 1, "R1");

        // constrained random mix
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] w;
            int sel;
            w = $urandom;
            sel = int'($urandom % 8);
            if (sel < 6) begin
                w[6:0] = ($urandom % 2 == 0) ? 7'h07 : 7'h27;
                w[24:20] = 5'd0;
                w[28:26] = ($urandom % 4 == 0) ? 3'b100 : (($urandom % 8 == 0) ? 3'($urandom) : 3'b000);
                case ($urandom % 4)
                    0: w[14:12] = 3'b000;
                    1: w[14:12] = 3'b101;
                    2: w[14:12] = 3'b110;
                    default: w[14:12] = 3'b111;
                endcase
                if ($urandom % 3 == 0) w[11:7] = 5'(($urandom % 4) * 8);
            end
            apply(w, 2'($urandom), 2'($urandom), ($urandom % 8) == 0, ($urandom % 8) != 0, "");
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule